// File: doc/BRIEF.md
# Memory Card SPI Command Engine

This block carries out one command exchange with a flash memory card that is attached in SPI mode. The caller presents a six-bit command index, a 32-bit argument and a response kind, then pulses `start`. The engine builds the six-byte command frame, including its CRC7 checksum, and sends it one byte at a time through a byte-exchange port. That port is a separate shifter that sends one byte and returns the byte it received. The engine then keeps sending filler bytes until the card answers. Depending on the response kind, it also collects a 32-bit trailer or waits for the card to finish a busy period.

The engine drives the card's chip select for the whole exchange. At the end it sends one more filler byte with chip select high, so that the card lets go of its data line before another device uses the bus. A single-cycle `done` pulse then reports the result: the first response byte, the trailer, and a timeout flag. The timeout flag is set when the card stays silent for too many bytes or stays busy for too long. These results stay unchanged until the next `start`.

Top module: `sd_cmd_engine`

## Requirements
- R1: Frame layout. Frame byte 0 is 2'b01 followed by the six-bit index. Bytes 1 to 4 carry the argument, most significant byte first. Byte 5 is the CRC7 shifted left by one with a 1 in bit 0. The CRC7 uses x^7+x^3+1 over the first 40 frame bits, which gives a byte 5 of 0x95 for index 0 with argument 0, and 0x87 for index 8 with argument 0x000001AA.
- R2: `cs_n` is low for every byte from the first frame byte through the last response or busy byte. After those, exactly one 0xFF byte is exchanged with `cs_n` high.
- R3: Every byte sent after the frame is 0xFF. The response byte is the first received byte whose bit 7 is 0, as long as it arrives within POLL_MAX polls. It appears on `r1`.
- R4: If none of the first POLL_MAX poll bytes has bit 7 clear, the engine ends with `timeout` = 1 and `r1` = 0xFF.
- R5: For `resp_type` 2 (R3) and 3 (R7), the four bytes after the response byte are gathered MSB first into `resp_data`.
- R6: For `resp_type` 2 or 3, a response byte with bit 2 set (illegal command) ends the exchange without reading a trailer, and `resp_data` stays 0.
- R7: For `resp_type` 1 (R1b), bytes are read after the response byte until a 0xFF arrives. If BUSY_MAX bytes arrive that are not 0xFF, the engine ends with `timeout` = 1. `resp_type` 0 is plain R1.
- R8: `xfer_req` stays high, with `tx_byte` unchanged, until `xfer_done` is seen. It then drops for at least one cycle.
- R9: `done` is a one-cycle pulse that comes while `cs_n` is high. `r1`, `resp_data` and `timeout` hold their values after `done` until the next accepted start.
- R10: A `start` pulse during an exchange in progress is ignored.
- R11: After reset: `cs_n` = 1, `xfer_req` = 0, `done` = 0, `timeout` = 0, `r1` = 0xFF, `resp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange when idle |
| cmd_index | input | 6 | Command index |
| arg | input | 32 | Command argument |
| resp_type | input | 2 | 0 R1, 1 R1b, 2 R3, 3 R7 |
| done | output | 1 | One-cycle end-of-exchange pulse |
| r1 | output | 8 | Response byte |
| resp_data | output | 32 | Trailing 32 bits for R3/R7 |
| timeout | output | 1 | No response or busy too long |
| cs_n | output | 1 | Card chip select, active low |
| tx_byte | output | 8 | Byte to send |
| xfer_req | output | 1 | Byte exchange request |
| rx_byte | input | 8 | Byte received, valid with xfer_done |
| xfer_done | input | 1 | Byte exchange complete |

## Verification
The hardest conditions to reach are the edges of the two bounded windows. One is a response that lands on the last allowed poll, or one byte past it. The other is a busy tail that ends with 0xFF exactly at the limit, or runs one byte over. The bench models the card as a per-exchange script of returned bytes. It sweeps the response position across the whole poll window plus one, filling the earlier poll bytes with values that are not 0xFF but still have bit 7 set. It sweeps the busy length from zero up to one past the limit, using a small busy limit. Rejection of a start during an exchange is reached by pulsing `start` while the frame is still being sent.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int POLL_MAX = 9,
  parameter int BUSY_MAX = 65536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] arg,
  input  logic [1:0]  resp_type,
  output logic        done,
  output logic [7:0]  r1,
  output logic [31:0] resp_data,
  output logic        timeout,
  output logic        cs_n,
  output logic [7:0]  tx_byte,
  output logic        xfer_req,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_done
);
  localparam int LIM = (BUSY_MAX > POLL_MAX) ? BUSY_MAX : POLL_MAX;
  localparam int CW  = $clog2(LIM + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_DATA, S_BUSY, S_REL} st_t;

  st_t         st;
  logic [47:0] frame;
  logic [1:0]  rtype;
  logic [CW-1:0] cnt;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ d[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  wire [39:0] head    = {2'b01, cmd_index, arg};
  wire [7:0]  tx_next = (st == S_CMD) ? frame[47:40] : 8'hFF;
  wire        got     = xfer_req && xfer_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      frame     <= '0;
      rtype     <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      r1        <= 8'hFF;
      resp_data <= '0;
      timeout   <= 1'b0;
      cs_n      <= 1'b1;
      tx_byte   <= 8'hFF;
      xfer_req  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          frame     <= {head, crc7(head), 1'b1};
          rtype     <= resp_type;
          cnt       <= '0;
          r1        <= 8'hFF;
          resp_data <= '0;
          timeout   <= 1'b0;
          cs_n      <= 1'b0;
          st        <= S_CMD;
        end
      end else if (got) begin
        xfer_req <= 1'b0;
        case (st)
          S_CMD: begin
            frame <= frame << 8;
            if (cnt == CW'(5)) begin
              cnt <= '0;
              st  <= S_POLL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_POLL: begin
            if (!rx_byte[7]) begin
              r1  <= rx_byte;
              cnt <= '0;
              if (rtype == 2'd1) begin
                st <= S_BUSY;
              end else if (rtype[1] && !rx_byte[2]) begin
                st <= S_DATA;
              end else begin
                st   <= S_REL;
                cs_n <= 1'b1;
              end
            end else if (cnt == CW'(POLL_MAX - 1)) begin
              timeout <= 1'b1;
              st      <= S_REL;
              cs_n    <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            resp_data <= {resp_data[23:0], rx_byte};
            if (cnt == CW'(3)) begin
              st   <= S_REL;
              cs_n <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BUSY: begin
            if (rx_byte == 8'hFF) begin
              st   <= S_REL;
              cs_n <= 1'b1;
            end else if (cnt == CW'(BUSY_MAX - 1)) begin
              timeout <= 1'b1;
              st      <= S_REL;
              cs_n    <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        endcase
      end else if (!xfer_req) begin
        xfer_req <= 1'b1;
        tx_byte  <= tx_next;
      end
    end
  end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [5:0]  cmd_index,
  input logic [31:0] arg,
  input logic [1:0]  resp_type,
  input logic        done,
  input logic [7:0]  r1,
  input logic [31:0] resp_data,
  input logic        timeout,
  input logic        cs_n,
  input logic [7:0]  tx_byte,
  input logic        xfer_req,
  input logic [7:0]  rx_byte,
  input logic        xfer_done
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(tx_byte));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done |=> !xfer_req);

  // R9
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && !xfer_req);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  release_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && cs_n |-> tx_byte == 8'hFF);

  // R1
  frame_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> xfer_req && tx_byte[7:6] == 2'b01);
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (.*);

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;
  localparam int PM = 9;
  localparam int BM = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [5:0] cmd_index = 0;
  logic [31:0] arg = 0;
  logic [1:0] resp_type = 0;
  logic done, timeout, cs_n, xfer_req;
  logic [7:0] r1, tx_byte;
  logic [31:0] resp_data;
  logic [7:0] rx_byte = 8'hFF;
  logic xfer_done = 0;

  always #5 clk = ~clk;

  sd_cmd_engine #(.POLL_MAX(PM), .BUSY_MAX(BM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index), .arg(arg),
    .resp_type(resp_type), .done(done), .r1(r1), .resp_data(resp_data),
    .timeout(timeout), .cs_n(cs_n), .tx_byte(tx_byte), .xfer_req(xfer_req),
    .rx_byte(rx_byte), .xfer_done(xfer_done));

  logic [7:0] script [64];
  logic [7:0] tx_log [64];
  logic       cs_log [64];
  int k = 0;
  int checks = 0, fails = 0;
  int cyc = 0;

  always @(negedge clk) begin
    if (xfer_done) xfer_done = 0;
    else if (xfer_req) begin
      if (k < 64) begin
        tx_log[k] = tx_byte;
        cs_log[k] = cs_n;
        rx_byte = script[k];
      end else rx_byte = 8'hFF;
      k = k + 1;
      xfer_done = 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles %0d expected under 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = c[6] ^ d[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [5:0] idx, input logic [31:0] a, input int i);
    logic [47:0] f = {2'b01, idx, a, ref_crc({2'b01, idx, a}), 1'b1};
    return f[47 - 8*i -: 8];
  endfunction

  task automatic clear_script();
    for (int i = 0; i < 64; i++) script[i] = 8'hFF;
  endtask

  task automatic run(input logic [5:0] idx, input logic [31:0] a, input logic [1:0] rt, input int inject);
    int n = 0;
    @(negedge clk);
    cmd_index = idx; arg = a; resp_type = rt; start = 1; k = 0;
    @(negedge clk);
    start = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
      if (n == inject) begin
        cmd_index = 6'h3F; arg = 32'hFFFF_FFFF; resp_type = 2'd3; start = 1;
      end else start = 0;
    end
    start = 0;
    chk(done, "R9 done arrives", {31'b0, done}, 1);
  endtask

  task automatic chk_cs(input string tag);
    for (int i = 0; i < k - 1; i++) chk(cs_log[i] == 0, tag, {31'b0, cs_log[i]}, 0);
    chk(cs_log[k-1] == 1 && tx_log[k-1] == 8'hFF, tag, {23'b0, cs_log[k-1], tx_log[k-1]}, 32'h1FF);
  endtask

  initial begin
    clear_script();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1 && xfer_req == 0 && done == 0 && timeout == 0, "R11 reset ctrl",
        {cs_n, xfer_req, done, timeout}, 32'h8);
    chk(r1 == 8'hFF && resp_data == 0, "R11 reset data", {r1, resp_data[23:0]}, 32'hFF000000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 CMD0 known frame
    clear_script(); script[6] = 8'h01;
    run(6'd0, 32'd0, 2'd0, 0);
    chk(tx_log[0] == 8'h40 && tx_log[1] == 0 && tx_log[4] == 0, "R1 cmd0 head", tx_log[0], 8'h40);
    chk(tx_log[5] == 8'h95, "R1 cmd0 crc", tx_log[5], 8'h95);
    chk(r1 == 8'h01 && !timeout && k == 8, "R3 cmd0 r1", {r1, 8'(k)}, 32'h0108);
    chk_cs("R2 cmd0 cs");

    // R1 R5 CMD8 with R7 trailer
    clear_script(); script[6] = 8'h01; script[7] = 8'h00; script[8] = 8'h00;
    script[9] = 8'h01; script[10] = 8'hAA;
    run(6'd8, 32'h0000_01AA, 2'd3, 0);
    chk(tx_log[5] == 8'h87, "R1 cmd8 crc", tx_log[5], 8'h87);
    chk(resp_data == 32'h0000_01AA && k == 12, "R5 r7 data", resp_data, 32'h1AA);
    chk_cs("R2 r7 cs");

    // R6 illegal command stops trailer
    clear_script(); script[6] = 8'h05; script[7] = 8'h12;
    run(6'd8, 32'h0000_01AA, 2'd3, 0);
    chk(r1 == 8'h05 && resp_data == 0 && k == 8, "R6 illegal", {r1, 8'(k), resp_data[15:0]}, 32'h05080000);

    // R5 R3 trailer
    clear_script(); script[8] = 8'h00; script[9] = 8'hC0; script[10] = 8'hFF;
    script[11] = 8'h80; script[12] = 8'h00; script[6] = 8'hFE; script[7] = 8'h9C;
    run(6'd58, 32'd0, 2'd2, 0);
    chk(resp_data == 32'hC0FF_8000 && r1 == 0 && k == 14, "R5 r3 data", resp_data, 32'hC0FF8000);

    // R3 R4 poll window sweep
    for (int p = 0; p <= PM; p++) begin
      clear_script();
      for (int i = 0; i < p; i++) script[6+i] = 8'h80 | 8'(i);
      script[6+p] = 8'h00;
      run(6'd17, 32'h0000_1000, 2'd0, 0);
      if (p < PM) begin
        chk(!timeout && r1 == 0 && k == 8 + p, "R3 poll pos", {timeout, 8'(k)}, 32'(8 + p));
      end else begin
        chk(timeout && r1 == 8'hFF && k == 6 + PM + 1, "R4 poll timeout", {timeout, 8'(k)}, 32'h100 | 32'(7 + PM));
      end
      for (int i = 6; i < k; i++) chk(tx_log[i] == 8'hFF, "R3 filler", tx_log[i], 8'hFF);
      chk_cs("R2 poll cs");
    end

    // R7 busy tail sweep
    for (int n = 0; n <= BM; n++) begin
      clear_script(); script[6] = 8'h00;
      for (int i = 0; i < n; i++) script[7+i] = 8'h00;
      run(6'd12, 32'd0, 2'd1, 0);
      if (n < BM) chk(!timeout && k == 9 + n, "R7 busy end", {timeout, 8'(k)}, 32'(9 + n));
      else chk(timeout && k == 8 + BM, "R7 busy timeout", {timeout, 8'(k)}, 32'h100 | 32'(8 + BM));
      chk_cs("R2 busy cs");
    end

    // R9 outputs hold after done
    repeat (5) @(negedge clk);
    chk(timeout && r1 == 8'h00 && cs_n, "R9 hold", {timeout, r1}, 32'h100);

    // R1 frame sweep over all indices
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a = 32'hA55A_0F00 ^ (32'(i) * 32'h0101_0107);
      bit ok = 1;
      clear_script(); script[6] = 8'h00;
      run(6'(i), a, 2'd0, 0);
      for (int b = 0; b < 6; b++) if (tx_log[b] != ref_byte(6'(i), a, b)) ok = 0;
      chk(ok, "R1 frame sweep", {tx_log[0], tx_log[5]}, {ref_byte(6'(i), a, 0), ref_byte(6'(i), a, 5)});
    end

    // R10 start during an exchange is ignored
    clear_script(); script[6] = 8'h00;
    run(6'd24, 32'h0000_0200, 2'd0, 4);
    chk(tx_log[0] == 8'h58 && tx_log[4] == 8'h00 && k == 8, "R10 ignored start", {tx_log[0], 8'(k)}, 32'h5808);
    repeat (10) @(negedge clk);
    chk(cs_n && !xfer_req && k == 8, "R10 no new exchange", {cs_n, xfer_req, 8'(k)}, 32'h208);

    summary();
  end
endmodule